// File: doc/BRIEF.md
# Saturating Arithmetic and Rounding Unit

This block is a small pipelined datapath that clamps arithmetic results to a chosen range instead of letting them wrap. It adds or subtracts two signed 32-bit words, or two pairs of packed signed 16-bit halfwords, and pins any overflowing result to the nearest representable limit. It also takes one operand, shifts it right arithmetically by a programmable amount and then forces the shifted value into a signed or unsigned field whose top bit index is programmable. One pair of operations rounds to nearest during the shift before clamping.

Every operation reports, with its result, whether clamping altered the value. The word and halfword add/subtract and the plain shift-and-clamp operations return their result one clock after issue. The rounding operations take two clocks and occupy the unit for both of them, so the issuer must leave one idle cycle after each rounding operation; an operation presented in that cycle is dropped.

Top module: `sat_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and on the first cycle after it, `out_valid`, `sat_flag` and `result` are all zero.
- R2: Opcode 0 returns a+b and opcode 1 returns a-b, both as signed 32-bit values clamped to [0x80000000, 0x7FFFFFFF].
- R3: `sat_flag` is 1 with a result exactly when clamping changed the value, and 0 otherwise.
- R4: Opcode 2 (add) and opcode 3 (subtract) treat bits 15:0 and 31:16 of each operand as two independent signed 16-bit lanes, each clamped to [0x8000, 0x7FFF] with no carry or borrow between lanes; the flag is set if either lane clamped.
- R5: Opcode 6 shifts `a` right arithmetically by `shamt` and clamps the value to the signed range [-2^pos, 2^pos-1]; `b` is not used.
- R6: Opcode 7 shifts `a` right arithmetically by `shamt` and clamps the value to the unsigned range [0, 2^(pos+1)-1], so a negative input yields zero.
- R7: Opcodes 4 (signed, range as R5) and 5 (unsigned, range as R6) first add 2^(shamt-1) to `a` when `shamt` is nonzero (no addition when it is zero), then shift right arithmetically by `shamt`, then clamp; the addition cannot overflow.
- R8: For opcodes 0-3, 6 and 7, `out_valid` rises for one cycle on the clock edge after the one that accepted the operation; for opcodes 4 and 5 it stays low at that edge and rises on the next.
- R9: An operation presented in the cycle right after an accepted rounding operation is ignored: it produces no `out_valid` pulse and does not change `result`.
- R10: When `out_valid` is low, `result` and `sat_flag` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation code (0-7, see requirements) |
| a | input | 32 | First operand; the only operand of shift operations |
| b | input | 32 | Second operand of add/subtract |
| pos | input | 5 | Top bit index of the clamp field |
| shamt | input | 5 | Right shift amount |
| out_valid | output | 1 | Result and flag are new this cycle |
| result | output | 32 | Clamped result |
| sat_flag | output | 1 | Clamping altered the value |

## Verification
A wrong value in the stage that holds a rounded intermediate shows at the ports on the very next edge, as a wrong result or a wrong flag, because that stage feeds only the output registers; a stuck occupancy bit shows either as a missing `out_valid` pulse two edges after a rounding issue or as a dropped operation that should have been accepted. The sweeps cover every combination of clamp position and shift amount for the four shift operations against a set of operands at the signed limits, so an off-by-one in the range bounds or in the rounding constant lands on a miscompare. Lane independence of the halfword operations is exercised with operands that overflow one lane and not the other.

// File: rtl/sat_unit.sv
module sat_unit #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] pos,
  input  logic [$clog2(W)-1:0] shamt,
  output logic                 out_valid,
  output logic [W-1:0]         result,
  output logic                 sat_flag
);
  localparam int SW    = $clog2(W);
  localparam int LANES = W / HW;

  localparam logic [2:0] OP_ADDW = 3'd0, OP_SUBW = 3'd1, OP_ADDH = 3'd2, OP_SUBH = 3'd3,
                         OP_RSATS = 3'd4, OP_RSATU = 3'd5, OP_SATS = 3'd6, OP_SATU = 3'd7;

  function automatic logic [W:0] clamp(input logic signed [W+1:0] x,
                                       input logic [SW-1:0] p, input logic uns);
    logic signed [W+1:0] hi, lo;
    if (uns) begin
      hi = ((W+2)'(2) << p) - (W+2)'(1);
      lo = '0;
    end else begin
      hi = ((W+2)'(1) << p) - (W+2)'(1);
      lo = -((W+2)'(1) << p);
    end
    if (x > hi)      return {1'b1, hi[W-1:0]};
    else if (x < lo) return {1'b1, lo[W-1:0]};
    else             return {1'b0, x[W-1:0]};
  endfunction

  logic                 s1_v, s1_uns;
  logic signed [W+1:0]  s1_x;
  logic [SW-1:0]        s1_pos;

  wire accept = in_valid & ~s1_v;
  wire is_rnd = (op == OP_RSATS) | (op == OP_RSATU);
  wire is_sub = op[0];

  // word add/sub
  logic signed [W:0] wsum;
  assign wsum = is_sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});
  wire         wovf = wsum[W] ^ wsum[W-1];
  wire [W-1:0] wres = wovf ? (wsum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                           : wsum[W-1:0];

  // packed halfword add/sub
  logic [W-1:0]     hres;
  logic [LANES-1:0] hflag;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire signed [HW:0] la = {a[l*HW+HW-1], a[l*HW +: HW]};
    wire signed [HW:0] lb = {b[l*HW+HW-1], b[l*HW +: HW]};
    wire signed [HW:0] ls = is_sub ? (la - lb) : (la + lb);
    assign hflag[l] = ls[HW] ^ ls[HW-1];
    assign hres[l*HW +: HW] = hflag[l] ? (ls[HW] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}})
                                       : ls[HW-1:0];
  end

  // shift paths
  logic signed [W+1:0] ext, rnd, xsh, xrn, xsum;
  assign ext  = {{2{a[W-1]}}, a};
  assign rnd  = (shamt == '0) ? '0 : ((W+2)'(1) << (shamt - 1'b1));
  assign xsum = ext + rnd;
  assign xsh  = ext >>> shamt;
  assign xrn  = xsum >>> shamt;

  logic [W:0] nres;
  always_comb begin
    case (op)
      OP_ADDW, OP_SUBW: nres = {wovf, wres};
      OP_ADDH, OP_SUBH: nres = {|hflag, hres};
      OP_SATS:          nres = clamp(xsh, pos, 1'b0);
      OP_SATU:          nres = clamp(xsh, pos, 1'b1);
      default:          nres = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_uns    <= 1'b0;
      s1_x      <= '0;
      s1_pos    <= '0;
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      s1_v      <= accept & is_rnd;
      out_valid <= s1_v | (accept & ~is_rnd);
      if (accept & is_rnd) begin
        s1_x   <= xrn;
        s1_pos <= pos;
        s1_uns <= (op == OP_RSATU);
      end
      if (s1_v)                    {sat_flag, result} <= clamp(s1_x, s1_pos, s1_uns);
      else if (accept & ~is_rnd)   {sat_flag, result} <= nres;
    end
  end
endmodule

module sat_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          sat_flag,
  input logic          s1_v,
  input logic          s1_uns,
  input logic [SW-1:0] s1_pos
);
  wire acc_rnd  = in_valid & ~s1_v & (op == 3'd4 || op == 3'd5);
  wire acc_fast = in_valid & ~s1_v & ~(op == 3'd4 || op == 3'd5);
  wire acc_word = in_valid & ~s1_v & (op <= 3'd1);

  a_r8_fast_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> out_valid);
  a_r8_round_gap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rnd |=> !out_valid);
  a_r8_round_done: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rnd |=> ##1 out_valid);
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> !s1_v);
  a_r2_word_limits: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_word) && sat_flag |->
      (result == {1'b0, {(W-1){1'b1}}} || result == {1'b1, {(W-1){1'b0}}}));
  a_r6_unsigned_range: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(s1_v && s1_uns) |-> ((result >> $past(s1_pos)) >> 1) == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result) && $stable(sat_flag));
endmodule

bind sat_unit sat_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .out_valid(out_valid),
  .result(result), .sat_flag(sat_flag), .s1_v(s1_v), .s1_uns(s1_uns), .s1_pos(s1_pos)
);

// File: tb/sat_unit_tb.sv
module sat_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  pos = '0, shamt = '0;
  logic        out_valid, sat_flag;
  logic [31:0] result;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sat_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
                  .pos(pos), .shamt(shamt), .out_valid(out_valid), .result(result),
                  .sat_flag(sat_flag));

  function automatic longint clampm(longint x, int p, bit u, output bit f);
    longint hi, lo;
    hi = u ? ((64'sd2 <<< p) - 1) : ((64'sd1 <<< p) - 1);
    lo = u ? 0 : -(64'sd1 <<< p);
    f = 1'b0;
    if (x > hi) begin f = 1'b1; return hi; end
    if (x < lo) begin f = 1'b1; return lo; end
    return x;
  endfunction

  function automatic logic [32:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                                        int p, int s);
    longint sx, sy, v, r;
    bit f, f1;
    logic [31:0] res;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      3'd0, 3'd1: begin
        v = (o == 3'd0) ? sx + sy : sx - sy;
        r = clampm(v, 31, 1'b0, f);
        res = r[31:0];
      end
      3'd2, 3'd3: begin
        f = 1'b0;
        for (int l = 0; l < 2; l++) begin
          longint la, lb;
          la = longint'($signed(x[l*16 +: 16]));
          lb = longint'($signed(y[l*16 +: 16]));
          v = (o == 3'd2) ? la + lb : la - lb;
          r = clampm(v, 15, 1'b0, f1);
          res[l*16 +: 16] = r[15:0];
          f = f | f1;
        end
      end
      default: begin
        v = sx;
        if ((o == 3'd4 || o == 3'd5) && s > 0) v = v + (64'sd1 <<< (s - 1));
        v = v >>> s;
        r = clampm(v, p, (o == 3'd5 || o == 3'd7), f);
        res = r[31:0];
      end
    endcase
    return {f, res};
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got flag=%0b result=%08h, expected flag=%0b result=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                     input int p, input int s, input string req);
    logic [32:0] e;
    e = model(o, x, y, p, s);
    @(negedge clk);
    op = o; a = x; b = y; pos = 5'(p); shamt = 5'(s); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (o == 3'd4 || o == 3'd5) begin
      check(out_valid == 1'b0, "R8 rounding result too early", {sat_flag, result}, e);
      @(negedge clk);
    end
    check(out_valid == 1'b1 && {sat_flag, result} == e, req, {sat_flag, result}, e);
  endtask

  localparam logic [31:0] WV [8] = '{32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h00000001,
                                      32'h00000000, 32'h40000000, 32'hc0000001, 32'h12345678};
  localparam logic [15:0] HV [6] = '{16'h7fff, 16'h8000, 16'hffff, 16'h0001, 16'h4000, 16'hc123};
  localparam logic [31:0] SV [6] = '{32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h00000005,
                                      32'h12345678, 32'hedcba987};

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == 0 && sat_flag == 0, "R1 in reset",
          {sat_flag, result}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && result == 0 && sat_flag == 0, "R1 after reset",
          {sat_flag, result}, 33'd0);

    // R2 R3 word add/sub over corner pairs
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int o = 0; o < 2; o++)
          run(3'(o), WV[i], WV[j], 0, 0, "R2/R3 word add-sub");

    // R4 R3 halfword lanes, each lane independent
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int o = 2; o < 4; o++) begin
          run(3'(o), {HV[i], HV[j]}, {HV[j], HV[i]}, 0, 0, "R4/R3 halfword lanes");
          run(3'(o), {HV[i], 16'h0001}, {HV[j], 16'h0002}, 0, 0, "R4 lane isolation");
        end

    // R5 R6 R7 full sweep of pos and shamt
    for (int p = 0; p < 32; p++)
      for (int s = 0; s < 32; s++)
        for (int k = 0; k < 6; k++) begin
          run(3'd6, SV[k], 32'hdeadbeef, p, s, "R5 signed shift-clamp");
          run(3'd7, SV[k], 32'hdeadbeef, p, s, "R6 unsigned shift-clamp");
          run(3'd4, SV[k], 32'hdeadbeef, p, s, "R7 rounding signed");
          run(3'd5, SV[k], 32'hdeadbeef, p, s, "R7 rounding unsigned");
        end

    // R7 rounding tie: 3 >> 1 rounds to 2, -3 >> 1 rounds to -1
    run(3'd4, 32'd3, 32'd0, 31, 1, "R7 round half up positive");
    run(3'd4, 32'hfffffffd, 32'd0, 31, 1, "R7 round half up negative");

    // R9 R10: op presented in the busy cycle is dropped
    begin
      logic [32:0] e, held;
      e = model(3'd4, 32'h00001234, 32'd0, 7, 4);
      @(negedge clk);
      op = 3'd4; a = 32'h00001234; b = 0; pos = 5'd7; shamt = 5'd4; in_valid = 1'b1;
      @(negedge clk);
      op = 3'd0; a = 32'h7fffffff; b = 32'h7fffffff;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1 && {sat_flag, result} == e, "R9 rounding result after drop",
            {sat_flag, result}, e);
      held = {sat_flag, result};
      @(negedge clk);
      check(out_valid == 1'b0 && {sat_flag, result} == held, "R9 dropped op gave no result",
            {sat_flag, result}, held);
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0 && {sat_flag, result} == held, "R10 hold while idle",
            {sat_flag, result}, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule